// File: doc/BRIEF.md
# EDO DRAM Refresh and Power-Up Sequencer

This block owns the refresh duty for an asynchronous EDO DRAM whose internal row counter picks the row to refresh. After reset it waits out a long power-up pause, then runs a fixed number of initialisation cycles. Each of these cycles pulls both column strobes low ahead of the row strobe. When that is done it raises a ready flag that lets the main access controller start normal traffic.

From then on an interval timer queues one refresh per period. A saturating backlog counter keeps the refreshes the access controller has not yet let through. The block asks for the bus with a request line and waits for a grant. Once granted, it issues the queued refresh cycles one after another. The row strobe, both column strobes and write enable come from this block while it holds the bus.

A self-refresh request parks the memory with both strobes held low. This is only allowed from idle with nothing queued. The row strobe is held low for a minimum time. On exit the block enforces a recovery gap, then runs one mandatory refresh cycle before it returns the bus. All timing values are parameters counted in clock cycles.

Top module: `edo_refresh_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, ras_n, ucas_n, lcas_n and we_n are 1, and ready and ref_req are 0.
- R2: After reset release no strobe falls for PWRUP_PAUSE cycles. Exactly INIT_CYCLES refresh cycles then run with ready and ref_req held at 0. After them ready rises and stays at 1.
- R3: In every refresh cycle, ucas_n and lcas_n (always equal) are low for exactly T_CSR cycles before ras_n falls. They return high exactly T_CHR cycles after ras_n falls.
- R4: we_n stays 1 at all times, so no refresh cycle can be taken as a write.
- R5: In a refresh cycle ras_n is low for exactly T_RAS cycles. Between two strobe cycles ras_n is high for at least max(T_RP, T_RC - T_RAS) cycles.
- R6: Once ready is 1, the interval timer adds one pending refresh every REF_INTERVAL cycles. ref_req is 1 while a refresh is pending, and the first request comes exactly REF_INTERVAL cycles after ready rises.
- R7: After ready, no strobe activity starts while ref_gnt is 0.
- R8: The backlog saturates at MAX_PEND. When the grant arrives, min(missed intervals, MAX_PEND) refresh cycles run back to back, and then ref_req returns to 0.
- R9: Self refresh starts only from idle with no refresh pending; a pending refresh is served first. The entry has the column strobes before the row strobe. ras_n stays low while sr_req is 1 and for at least T_RASS cycles.
- R10: After self refresh, ras_n stays high for at least T_RPS cycles, and exactly one refresh cycle follows. An sr_req raised during this recovery is ignored until that cycle has completed.
- R11: The interval timer and the backlog are cleared during self refresh and its post-exit cycle. No refresh is requested for the first half interval after the post-exit cycle ends, however long self refresh lasted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_gnt | input | 1 | Bus grant from the access controller, held while ref_req is 1 |
| sr_req | input | 1 | Level request to enter and stay in self refresh |
| ref_req | output | 1 | Bus request: refresh pending or the sequencer is holding the bus |
| ready | output | 1 | Initialisation complete; normal accesses allowed |
| ras_n | output | 1 | Row address strobe, active low |
| ucas_n | output | 1 | Upper column strobe, active low |
| lcas_n | output | 1 | Lower column strobe, active low |
| we_n | output | 1 | Write enable, active low (held inactive) |

## Verification
Two situations are the hardest to bring about from the ports. The first is a saturated backlog: the bench withholds the grant for a number of full intervals, counted from a request edge, so that the backlog passes MAX_PEND. The second is a self-refresh request that lands inside the exit recovery window. To reach it, the bench drops sr_req, watches for the row strobe to rise, and raises sr_req again two cycles later, while recovery is still running. It then checks that the next row strobe pulse has ordinary refresh width before a second self-refresh pulse appears. A long self-refresh hold that spans several intervals shows that no stale backlog remains at exit.

// File: rtl/edo_refresh_pkg.sv
// Shared types for the EDO refresh sequencer.
// Assumes: all timing parameters are counted in clock cycles of the block clock.
package edo_refresh_pkg;

    // Strobe engine phases
    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_SETUP,      // column strobes low, row strobe high
        ENG_STROBE,     // both low
        ENG_ACTIVE,     // row strobe low, column strobes high
        ENG_PRECH,      // both high, precharge
        ENG_SR_HOLD,    // self refresh: both low
        ENG_SR_RECOVER  // self refresh exit gap
    } eng_state_t;

    // Top-level sequencing states
    typedef enum logic [2:0] {
        SEQ_PAUSE,
        SEQ_INIT,
        SEQ_IDLE,
        SEQ_REFRESH,
        SEQ_SELF,
        SEQ_POST
    } seq_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_cbr_engine.sv
// Strobe engine: produces one CAS-before-RAS refresh cycle or a self-refresh
// hold on request. A single down-counter times every phase.
// Assumes: start pulses arrive only while idle; T_RAS > T_CHR; all times >= 1.
module edo_cbr_engine
    import edo_refresh_pkg::*;
#(
    parameter int T_CSR  = 2,
    parameter int T_CHR  = 2,
    parameter int T_RAS  = 10,
    parameter int T_PRE  = 7,
    parameter int T_RASS = 20000,
    parameter int T_RPS  = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_cbr,
    input  logic start_sr,
    input  logic sr_keep,
    output logic eng_idle,
    output logic cbr_done,
    output logic sr_done,
    output logic ras_n,
    output logic cas_n
);
    localparam int CNT_MAX = max2(max2(max2(T_CSR, T_CHR), max2(T_RAS, T_PRE)),
                                  max2(T_RASS, T_RPS));
    localparam int CW = $clog2(CNT_MAX + 1);

    eng_state_t    state, state_d;
    logic [CW-1:0] cnt, cnt_d;
    logic          sr_mode, sr_mode_d;

    // Next phase, counter reload and completion pulses
    always_comb begin
        state_d   = state;
        cnt_d     = cnt;
        sr_mode_d = sr_mode;
        cbr_done  = 1'b0;
        sr_done   = 1'b0;
        case (state)
            ENG_IDLE: begin
                if (start_sr || start_cbr) begin
                    state_d   = ENG_SETUP;
                    cnt_d     = CW'(T_CSR - 1);
                    sr_mode_d = start_sr;
                end
            end
            ENG_SETUP: begin
                if (cnt == '0) begin
                    if (sr_mode) begin
                        state_d = ENG_SR_HOLD;
                        cnt_d   = CW'(T_RASS - 1);
                    end else begin
                        state_d = ENG_STROBE;
                        cnt_d   = CW'(T_CHR - 1);
                    end
                end else begin
                    cnt_d = cnt - 1'b1;
                end
            end
            ENG_STROBE: begin
                if (cnt == '0) begin
                    state_d = ENG_ACTIVE;
                    cnt_d   = CW'(T_RAS - T_CHR - 1);
                end else begin
                    cnt_d = cnt - 1'b1;
                end
            end
            ENG_ACTIVE: begin
                if (cnt == '0) begin
                    state_d = ENG_PRECH;
                    cnt_d   = CW'(T_PRE - 1);
                end else begin
                    cnt_d = cnt - 1'b1;
                end
            end
            ENG_PRECH: begin
                if (cnt == '0) begin
                    state_d  = ENG_IDLE;
                    cbr_done = 1'b1;
                end else begin
                    cnt_d = cnt - 1'b1;
                end
            end
            ENG_SR_HOLD: begin
                if (cnt != '0) begin
                    cnt_d = cnt - 1'b1;
                end else if (!sr_keep) begin
                    state_d = ENG_SR_RECOVER;
                    cnt_d   = CW'(T_RPS - 1);
                end
            end
            ENG_SR_RECOVER: begin
                if (cnt == '0) begin
                    state_d = ENG_IDLE;
                    sr_done = 1'b1;
                end else begin
                    cnt_d = cnt - 1'b1;
                end
            end
            default: state_d = ENG_IDLE;
        endcase
    end

    // Phase registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ENG_IDLE;
            cnt     <= '0;
            sr_mode <= 1'b0;
        end else begin
            state   <= state_d;
            cnt     <= cnt_d;
            sr_mode <= sr_mode_d;
        end
    end

    // Strobe decode from the registered phase
    always_comb begin
        ras_n    = !(state == ENG_STROBE || state == ENG_ACTIVE || state == ENG_SR_HOLD);
        cas_n    = !(state == ENG_SETUP || state == ENG_STROBE || state == ENG_SR_HOLD);
        eng_idle = (state == ENG_IDLE);
    end

    // Checker counters: length of the current low and high row-strobe runs
    logic [31:0] ras_lo_run, ras_hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lo_run <= '0;
            ras_hi_run <= 32'(CNT_MAX + 1);
        end else begin
            ras_lo_run <= ras_n ? '0 : ras_lo_run + 1'b1;
            if (!ras_n)
                ras_hi_run <= '0;
            else if (ras_hi_run < 32'(CNT_MAX + 1))
                ras_hi_run <= ras_hi_run + 1'b1;
        end
    end

    assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && !sr_mode) |-> (ras_lo_run == 32'(T_RAS)));

    assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_hi_run >= 32'(T_PRE)));

    assert_sr_min_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && sr_mode) |-> (ras_lo_run >= 32'(T_RASS)));

endmodule

// File: rtl/edo_ref_interval.sv
// Interval timer and saturating backlog of refreshes not yet served.
// Assumes: served pulses only while the backlog is non-zero or are harmless at 0.
module edo_ref_interval #(
    parameter int REF_INTERVAL = 3120,
    parameter int MAX_PEND     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic served,
    output logic pend_nz
);
    localparam int TW = $clog2(REF_INTERVAL + 1);
    localparam int PW = $clog2(MAX_PEND + 1);

    logic [TW-1:0] tmr;
    logic [PW-1:0] pend, pend_d;
    logic          tick;

    assign tick = run && (tmr == TW'(REF_INTERVAL - 1));

    // Interval counter, held at zero when stopped or cleared
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run)
            tmr <= '0;
        else if (tick)
            tmr <= '0;
        else
            tmr <= tmr + 1'b1;
    end

    // Backlog update: add on tick, remove on service, saturate both ways
    always_comb begin
        pend_d = pend;
        if (tick && !served && pend != PW'(MAX_PEND))
            pend_d = pend + 1'b1;
        else if (served && !tick && pend != '0)
            pend_d = pend - 1'b1;
    end

    // Backlog register
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            pend <= '0;
        else
            pend <= pend_d;
    end

    assign pend_nz = (pend != '0);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PW'(MAX_PEND));

    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pend == '0));

endmodule

// File: rtl/edo_seq_ctrl.sv
// Sequencing controller: power-up pause, initialisation cycles, bus
// request/grant, refresh dispatch and self-refresh entry and exit.
// Assumes: the access controller keeps ref_gnt high while ref_req is high.
module edo_seq_ctrl
    import edo_refresh_pkg::*;
#(
    parameter int PWRUP_PAUSE = 40000000,
    parameter int INIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    input  logic sr_req,
    input  logic eng_idle,
    input  logic cbr_done,
    input  logic sr_done,
    input  logic pend_nz,
    output logic start_cbr,
    output logic start_sr,
    output logic ref_req,
    output logic ready,
    output logic timer_run,
    output logic timer_clear,
    output logic served
);
    localparam int PCW = $clog2(PWRUP_PAUSE + 1);
    localparam int ICW = $clog2(INIT_CYCLES + 1);

    seq_state_t     state, state_d;
    logic [PCW-1:0] pause_cnt;
    logic [ICW-1:0] init_left;
    logic           ready_q;

    // Next state and engine start pulses
    always_comb begin
        state_d   = state;
        start_cbr = 1'b0;
        start_sr  = 1'b0;
        case (state)
            SEQ_PAUSE:
                if (pause_cnt == PCW'(PWRUP_PAUSE - 1)) state_d = SEQ_INIT;
            SEQ_INIT: begin
                start_cbr = eng_idle;
                if (cbr_done && init_left == ICW'(1)) state_d = SEQ_IDLE;
            end
            SEQ_IDLE: begin
                if (ref_gnt) begin
                    if (pend_nz)     state_d = SEQ_REFRESH;
                    else if (sr_req) state_d = SEQ_SELF;
                end
            end
            SEQ_REFRESH: begin
                start_cbr = eng_idle;
                if (cbr_done) state_d = SEQ_IDLE;
            end
            SEQ_SELF: begin
                start_sr = eng_idle;
                if (sr_done) state_d = SEQ_POST;
            end
            SEQ_POST: begin
                start_cbr = eng_idle;
                if (cbr_done) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_PAUSE;
        endcase
    end

    // State, pause counter, remaining init cycles and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_PAUSE;
            pause_cnt <= '0;
            init_left <= ICW'(INIT_CYCLES);
            ready_q   <= 1'b0;
        end else begin
            state <= state_d;
            if (state == SEQ_PAUSE)
                pause_cnt <= pause_cnt + 1'b1;
            if (state == SEQ_INIT && cbr_done)
                init_left <= init_left - 1'b1;
            if (state == SEQ_INIT && state_d == SEQ_IDLE)
                ready_q <= 1'b1;
        end
    end

    // Handshake and timer controls
    always_comb begin
        ready       = ready_q;
        ref_req     = (state == SEQ_REFRESH) || (state == SEQ_SELF) || (state == SEQ_POST) ||
                      ((state == SEQ_IDLE) && (pend_nz || sr_req));
        timer_clear = (state == SEQ_SELF) || (state == SEQ_POST);
        timer_run   = ready_q && !timer_clear;
        served      = cbr_done && (state == SEQ_REFRESH);
    end

    assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_no_req_before_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !ref_req);

    assert_start_needs_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_cbr || start_sr) && ready) |-> ref_gnt);

    assert_sr_from_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_sr |-> $past(!pend_nz));

endmodule

// File: rtl/edo_refresh_seq.sv
// Top level of the EDO DRAM refresh and power-up sequencer. Wires the
// controller, the interval timer and the strobe engine together.
// Assumes: T_RAS > T_CHR, all timing parameters >= 1 cycle.
module edo_refresh_seq
    import edo_refresh_pkg::*;
#(
    parameter int PWRUP_PAUSE  = 40000000,
    parameter int INIT_CYCLES  = 8,
    parameter int REF_INTERVAL = 3120,
    parameter int MAX_PEND     = 4,
    parameter int T_CSR        = 2,
    parameter int T_CHR        = 2,
    parameter int T_RAS        = 10,
    parameter int T_RP         = 6,
    parameter int T_RC         = 17,
    parameter int T_RASS       = 20000,
    parameter int T_RPS        = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    input  logic sr_req,
    output logic ref_req,
    output logic ready,
    output logic ras_n,
    output logic ucas_n,
    output logic lcas_n,
    output logic we_n
);
    localparam int T_PRE = max2(T_RP, T_RC - T_RAS);

    logic eng_idle, cbr_done, sr_done, eng_cas_n;
    logic start_cbr, start_sr, pend_nz;
    logic timer_run, timer_clear, served;

    edo_seq_ctrl #(
        .PWRUP_PAUSE (PWRUP_PAUSE),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_gnt     (ref_gnt),
        .sr_req      (sr_req),
        .eng_idle    (eng_idle),
        .cbr_done    (cbr_done),
        .sr_done     (sr_done),
        .pend_nz     (pend_nz),
        .start_cbr   (start_cbr),
        .start_sr    (start_sr),
        .ref_req     (ref_req),
        .ready       (ready),
        .timer_run   (timer_run),
        .timer_clear (timer_clear),
        .served      (served)
    );

    edo_ref_interval #(
        .REF_INTERVAL (REF_INTERVAL),
        .MAX_PEND     (MAX_PEND)
    ) u_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .clear   (timer_clear),
        .served  (served),
        .pend_nz (pend_nz)
    );

    edo_cbr_engine #(
        .T_CSR  (T_CSR),
        .T_CHR  (T_CHR),
        .T_RAS  (T_RAS),
        .T_PRE  (T_PRE),
        .T_RASS (T_RASS),
        .T_RPS  (T_RPS)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cbr (start_cbr),
        .start_sr  (start_sr),
        .sr_keep   (sr_req),
        .eng_idle  (eng_idle),
        .cbr_done  (cbr_done),
        .sr_done   (sr_done),
        .ras_n     (ras_n),
        .cas_n     (eng_cas_n)
    );

    // Both byte lanes refresh together; write enable stays inactive
    always_comb begin
        ucas_n = eng_cas_n;
        lcas_n = eng_cas_n;
        we_n   = 1'b1;
    end

endmodule

// File: tb/edo_refresh_seq_bench.sv
module edo_refresh_seq_bench;
    localparam int PAUSE    = 50;
    localparam int NINIT    = 8;
    localparam int INTERVAL = 200;
    localparam int MAXP     = 3;
    localparam int TCSR     = 2;
    localparam int TCHR     = 2;
    localparam int TRAS     = 10;
    localparam int TRP      = 6;
    localparam int TRC      = 17;
    localparam int TRASS    = 40;
    localparam int TRPS     = 19;
    localparam int TPRE     = (TRP > TRC - TRAS) ? TRP : TRC - TRAS;

    // Backlog table: intervals missed while grant is withheld -> cycles expected
    localparam int NROWS = 4;
    localparam int MISS_TAB [NROWS] = '{1, 2, 3, 5};
    localparam int EXP_TAB  [NROWS] = '{1, 2, 3, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic sr_req = 1'b0;
    logic ref_req, ready, ras_n, ucas_n, lcas_n, we_n;

    always #2.5 clk = ~clk;

    edo_refresh_seq #(
        .PWRUP_PAUSE (PAUSE), .INIT_CYCLES (NINIT), .REF_INTERVAL (INTERVAL),
        .MAX_PEND (MAXP), .T_CSR (TCSR), .T_CHR (TCHR), .T_RAS (TRAS),
        .T_RP (TRP), .T_RC (TRC), .T_RASS (TRASS), .T_RPS (TRPS)
    ) u_edo_refresh_seq (
        .clk (clk), .rst_n (rst_n), .ref_gnt (ref_gnt), .sr_req (sr_req),
        .ref_req (ref_req), .ready (ready), .ras_n (ras_n),
        .ucas_n (ucas_n), .lcas_n (lcas_n), .we_n (we_n)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Strobe monitor
    int  cyc = 0, falls = 0, rises = 0, first_fall = -1;
    int  cas_only = 0, cas_in_ras = 0, lo_len = 0, hi_len = 1000, last_lo = 0;
    int  we_bad = 0, lane_bad = 0, early_req = 0;
    bit  prev_ras = 1'b1, prev_cas = 1'b1, post_sr = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!we_n) we_bad++;
            if (ucas_n != lcas_n) lane_bad++;
            if (!ready && ref_req) early_req++;
            if (prev_ras && !ras_n) begin
                falls++;
                if (first_fall < 0) first_fall = cyc;
                check(!ucas_n && cas_only == TCSR, "R3 cas lead", cas_only, TCSR);
                check(hi_len >= TPRE, "R5 precharge", hi_len, TPRE);
                if (ready) check(ref_gnt, "R7 grant at strobe", ref_gnt, 1);
                if (post_sr) check(hi_len >= TRPS, "R10 exit gap", hi_len, TRPS);
                lo_len = 1;
                cas_in_ras = ucas_n ? 0 : 1;
            end else if (!ras_n) begin
                lo_len++;
                if (!ucas_n) cas_in_ras++;
            end
            if (!prev_cas && ucas_n && !ras_n)
                check(cas_in_ras == TCHR, "R3 cas hold", cas_in_ras, TCHR);
            if (!prev_ras && ras_n) begin
                rises++;
                last_lo = lo_len;
                if (post_sr) begin
                    check(lo_len == TRAS, "R10 post-exit cycle", lo_len, TRAS);
                    post_sr = 1'b0;
                end else if (lo_len > TRAS) begin
                    check(lo_len >= TRASS, "R9 self hold", lo_len, TRASS);
                    post_sr = 1'b1;
                end else begin
                    check(lo_len == TRAS, "R5 ras width", lo_len, TRAS);
                end
                hi_len = 1;
            end else if (ras_n) begin
                hi_len++;
            end
            if (!ucas_n && ras_n) cas_only++;
            else if (ucas_n) cas_only = 0;
            prev_ras = ras_n;
            prev_cas = ucas_n;
        end
    end

    // Watchdog
    int wd = 0;
    always @(negedge clk) begin
        wd++;
        if (wd > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wait_rises(input int n);
        int t0;
        t0 = rises;
        while (rises < t0 + n) @(negedge clk);
    endtask

    task automatic wait_falls(input int n);
        int t0;
        t0 = falls;
        while (falls < t0 + n) @(negedge clk);
    endtask

    initial begin
        int n, e0;
        // R1: reset state
        repeat (4) @(negedge clk);
        check(ras_n && ucas_n && lcas_n && we_n, "R1 strobes in reset",
              {ras_n, ucas_n, lcas_n, we_n}, 15);
        check(!ready && !ref_req, "R1 flags in reset", {ready, ref_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ras_n && ucas_n && !ready && !ref_req, "R1 first cycle",
              {ras_n, ucas_n, ready, ref_req}, 12);

        // R2: pause then init cycles
        while (!ready) @(negedge clk);
        check(first_fall >= PAUSE, "R2 pause", first_fall, PAUSE);
        check(falls == NINIT, "R2 init count", falls, NINIT);
        check(early_req == 0, "R2 no request before ready", early_req, 0);

        // R6: first request exactly one interval after ready
        n = 0;
        while (!ref_req) begin
            @(negedge clk);
            n++;
        end
        check(n == INTERVAL, "R6 interval", n, INTERVAL);

        // R7/R8: backlog table
        for (int r = 0; r < NROWS; r++) begin
            while (!ref_req) @(negedge clk);
            e0 = falls;
            repeat ((MISS_TAB[r] - 1) * INTERVAL + INTERVAL / 2) @(negedge clk);
            check(falls == e0 && ras_n, "R7 quiet without grant", falls - e0, 0);
            check(ref_req, "R6 request held", ref_req, 1);
            ref_gnt = 1'b1;
            while (ref_req) @(negedge clk);
            check(falls - e0 == EXP_TAB[r], "R8 backlog burst", falls - e0, EXP_TAB[r]);
            ref_gnt = 1'b0;
        end

        // R9/R11: pending refresh first, long self refresh, cleared timer
        while (!ref_req) @(negedge clk);
        e0 = falls;
        sr_req = 1'b1;
        ref_gnt = 1'b1;
        wait_rises(1);
        check(last_lo == TRAS, "R9 pending served first", last_lo, TRAS);
        wait_falls(1);
        repeat (450) @(negedge clk);
        sr_req = 1'b0;
        wait_rises(1);
        check(last_lo >= 450, "R9 held while requested", last_lo, 450);
        wait_rises(1);
        while (ref_req) @(negedge clk);
        check(falls - e0 == 3, "R10 one post-exit cycle", falls - e0, 3);
        e0 = falls;
        repeat (INTERVAL / 2) begin
            @(negedge clk);
            if (ref_req) break;
        end
        check(!ref_req && falls == e0, "R11 timer cleared", ref_req, 0);
        ref_gnt = 1'b0;

        // R9/R10: minimum hold and request during recovery
        while (ref_req) @(negedge clk);
        sr_req = 1'b1;
        while (!ref_req) @(negedge clk);
        ref_gnt = 1'b1;
        wait_falls(1);
        repeat (3) @(negedge clk);
        sr_req = 1'b0;
        wait_rises(1);
        check(last_lo == TRASS, "R9 minimum hold", last_lo, TRASS);
        repeat (2) @(negedge clk);
        sr_req = 1'b1;
        wait_rises(1);
        check(last_lo == TRAS, "R10 re-request ignored", last_lo, TRAS);
        wait_falls(1);
        repeat (3) @(negedge clk);
        sr_req = 1'b0;
        wait_rises(1);
        check(last_lo == TRASS, "R10 re-entry after post cycle", last_lo, TRASS);
        wait_rises(1);
        while (ref_req) @(negedge clk);
        ref_gnt = 1'b0;

        // R4 and lane equality over the whole run
        check(we_bad == 0, "R4 write enable high", we_bad, 0);
        check(lane_bad == 0, "R3 lanes equal", lane_bad, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule